// File: doc/BRIEF.md
# LCD Scan and Blink Timing Generator

This block produces every display-rate timing signal a multiplexed character LCD controller needs. From a raw input clock tick it derives an internal reference tick, either passing the tick straight through (crystal mode) or dividing it by 2, 4, 8 or 16 (external-clock mode). It then steps a common-line scan index, flips a frame-alternation bit once per full scan and toggles a slow blink phase. With a 32.768 kHz internal reference, the blink phase gives a 1 Hz blink and the frame rate is about 65 Hz at 1/9 duty or about 68.8 Hz at 1/17 duty.

A one-cycle pulse marks the end of each common line. The block's own command-busy flag uses this pulse: a received byte raises busy, and busy clears after two common-line periods. A blank output tells the segment and common drivers to sit at the idle level. Blank is raised when the display is switched off and when the device is in standby. Standby also freezes all timing. Display-off only blanks the panel, and the scan keeps running.

Top module: `lcd_scan_timer`

## Requirements
- R1: With `xtal_mode`=1 every `src_tick` is an internal tick and `div_sel` has no effect. With `xtal_mode`=0 one internal tick occurs per 2, 4, 8 or 16 `src_tick`s for `div_sel` = 0, 1, 2 or 3.
- R2: With `duty9`=1, `com_idx` steps 0,1,…,8 and then returns to 0. With `duty9`=0 it steps 0 through 16 and then returns to 0. After a duty change, the first line end that finds `com_idx` at or above the new last index returns it to 0.
- R3: A common line lasts 56 internal ticks with `duty9`=1 and 28 internal ticks with `duty9`=0. `line_tick` is high for exactly one cycle per line. It is high in the first cycle in which `com_idx` shows its new value.
- R4: `frame_alt` toggles exactly when `com_idx` returns to 0, so it toggles once per frame of 9 or 17 lines.
- R5: `blink_ph` toggles once every 16384 internal ticks. It starts at 0 after reset.
- R6: `busy` is high in the cycle after a `byte_strobe`. It stays high through the first following `line_tick` and is low from the cycle that shows the second following `line_tick`.
- R7: `blank` is 1 whenever `disp_on`=0 or `standby`=1. While `disp_on`=0 and `standby`=0, the scan keeps advancing.
- R8: While `standby`=1 no internal ticks occur. All counters hold, `line_tick` stays 0, and `com_idx`, `frame_alt` and `blink_ph` are stable. When `standby` is cleared, scanning resumes.
- R9: After reset, `com_idx`=0, `frame_alt`=0, `blink_ph`=0, `line_tick`=0 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | One-cycle tick of the oscillator source |
| xtal_mode | input | 1 | 1: crystal source used undivided; 0: external source, prescaled |
| div_sel | input | 2 | Prescale select in external mode (÷2/÷4/÷8/÷16) |
| duty9 | input | 1 | 1: 9 common lines; 0: 17 common lines |
| disp_on | input | 1 | Display enable |
| standby | input | 1 | Standby: stops all timing |
| byte_strobe | input | 1 | One-cycle pulse when a full byte has been received |
| com_idx | output | 5 | Active common line index |
| frame_alt | output | 1 | Frame-alternation (drive inversion) bit |
| blink_ph | output | 1 | Blink phase |
| line_tick | output | 1 | End-of-common-line pulse |
| busy | output | 1 | Command execution in progress |
| blank | output | 1 | Drive all outputs to the idle level |

## Verification
The bench measures the spacing between line pulses for every prescale setting in both duty modes. This includes crystal mode with a nonzero divide select, so a prescaler that leaked into crystal mode would show the wrong period. It counts the lines per frame-bit toggle in both duties. This catches a scan that wraps one line early or one line late, or that flips the frame bit at the wrong index. The busy check looks at both line pulses after a strobe: a timer that cleared after one line, or after three, fails. The standby check confirms that the scan index freezes, and the display-off check confirms that scanning continues while the panel is blanked.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int LINE9      = 56,
  parameter int LINE17     = 28,
  parameter int COM9       = 9,
  parameter int COM17      = 17,
  parameter int BLINK_HALF = 16384,
  parameter int COMW       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_tick,
  input  logic            xtal_mode,
  input  logic [1:0]      div_sel,
  input  logic            duty9,
  input  logic            disp_on,
  input  logic            standby,
  input  logic            byte_strobe,
  output logic [COMW-1:0] com_idx,
  output logic            frame_alt,
  output logic            blink_ph,
  output logic            line_tick,
  output logic            busy,
  output logic            blank
);
  localparam int LW = $clog2(LINE9 > LINE17 ? LINE9 : LINE17);
  localparam int BW = $clog2(BLINK_HALF);
  localparam logic [LW-1:0]   L9_LAST  = LW'(LINE9 - 1);
  localparam logic [LW-1:0]   L17_LAST = LW'(LINE17 - 1);
  localparam logic [COMW-1:0] C9_LAST  = COMW'(COM9 - 1);
  localparam logic [COMW-1:0] C17_LAST = COMW'(COM17 - 1);
  localparam logic [BW-1:0]   B_LAST   = BW'(BLINK_HALF - 1);

  logic [3:0]    pre_cnt;
  logic [LW-1:0] line_cnt;
  logic [BW-1:0] blink_cnt;
  logic          busy_cnt;

  logic [4:0] pre_lim;
  assign pre_lim = (5'd2 << div_sel) - 5'd1;

  logic pre_hit, int_tick, line_end, line_ev, com_wrap;
  assign pre_hit  = xtal_mode || ({1'b0, pre_cnt} >= pre_lim);
  assign int_tick = src_tick && !standby && pre_hit;
  assign line_end = line_cnt >= (duty9 ? L9_LAST : L17_LAST);
  assign line_ev  = int_tick && line_end;
  assign com_wrap = com_idx >= (duty9 ? C9_LAST : C17_LAST);
  assign blank    = !disp_on || standby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (xtal_mode) begin
      pre_cnt <= '0;
    end else if (src_tick && !standby) begin
      pre_cnt <= pre_hit ? 4'd0 : pre_cnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      com_idx   <= '0;
      frame_alt <= 1'b0;
      line_tick <= 1'b0;
    end else begin
      line_tick <= line_ev;
      if (int_tick) line_cnt <= line_end ? '0 : line_cnt + 1'b1;
      if (line_ev) begin
        com_idx <= com_wrap ? '0 : com_idx + 1'b1;
        if (com_wrap) frame_alt <= !frame_alt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blink_cnt <= '0;
      blink_ph  <= 1'b0;
    end else if (int_tick) begin
      if (blink_cnt == B_LAST) begin
        blink_cnt <= '0;
        blink_ph  <= !blink_ph;
      end else begin
        blink_cnt <= blink_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busy_cnt <= 1'b0;
    end else if (byte_strobe) begin
      busy     <= 1'b1;
      busy_cnt <= 1'b0;
    end else if (busy && line_ev) begin
      if (busy_cnt) busy <= 1'b0;
      busy_cnt <= 1'b1;
    end
  end

  AST_COM_IN_DUTY9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && duty9 && $past(duty9)) |-> (com_idx <= C9_LAST)) else $error("com range"); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> !line_tick) else $error("tick width"); // R3
  AST_FRAME_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_alt != $past(frame_alt)) |-> (com_idx == '0)) else $error("frame flip"); // R4
  AST_BUSY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_strobe |=> busy) else $error("busy rise"); // R6
  AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> ($stable(com_idx) && $stable(blink_ph) && !line_tick)) else $error("standby"); // R8
endmodule

// File: tb/lcd_scan_timer_tb_top.sv
module lcd_scan_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_tick = 1'b1, xtal_mode = 1'b1, duty9 = 1'b0;
  logic disp_on = 1'b1, standby = 1'b0, byte_strobe = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [4:0] com_idx;
  logic frame_alt, blink_ph, line_tick, busy, blank;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = !clk;

  lcd_scan_timer dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .xtal_mode(xtal_mode),
    .div_sel(div_sel), .duty9(duty9), .disp_on(disp_on), .standby(standby),
    .byte_strobe(byte_strobe), .com_idx(com_idx), .frame_alt(frame_alt),
    .blink_ph(blink_ph), .line_tick(line_tick), .busy(busy), .blank(blank)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!line_tick && n < 5000);
  endtask

  // {xtal_mode, div_sel, duty9, expected line period in clk cycles}
  localparam logic [14:0] VEC [8] = '{
    {1'b1, 2'd0, 1'b0, 11'd28},
    {1'b1, 2'd3, 1'b0, 11'd28},
    {1'b1, 2'd2, 1'b1, 11'd56},
    {1'b0, 2'd0, 1'b0, 11'd56},
    {1'b0, 2'd1, 1'b1, 11'd224},
    {1'b0, 2'd2, 1'b0, 11'd224},
    {1'b0, 2'd3, 1'b0, 11'd448},
    {1'b0, 2'd3, 1'b1, 11'd896}
  };

  initial begin
    int n, c0, lines;
    logic f0, b0;
    #3;
    check("R9 com_idx", com_idx, 0);
    check("R9 frame_alt", frame_alt, 0);
    check("R9 blink_ph", blink_ph, 0);
    check("R9 line_tick", line_tick, 0);
    check("R9 busy", busy, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      xtal_mode = VEC[i][14];
      div_sel   = VEC[i][13:12];
      duty9     = VEC[i][11];
      next_tick(n);
      next_tick(n);
      c0 = com_idx;
      next_tick(n);
      check("R1/R3 line period", n, int'(VEC[i][10:0]));
      check("R2 com step", com_idx, (c0 + 1) % (duty9 ? 9 : 17));
    end

    for (int d = 0; d < 2; d++) begin
      @(negedge clk);
      xtal_mode = 1'b1;
      duty9 = (d == 0);
      f0 = frame_alt;
      n = 0;
      while (frame_alt == f0 && n < 20000) begin @(negedge clk); n++; end
      check("R4 frame flip at com 0", com_idx, 0);
      f0 = frame_alt;
      lines = 0;
      n = 0;
      do begin
        @(negedge clk);
        n++;
        if (line_tick) lines++;
      end while (frame_alt == f0 && n < 20000);
      check("R4 lines per frame", lines, duty9 ? 9 : 17);
      check("R2 wrap to zero", com_idx, 0);
    end

    b0 = blink_ph;
    n = 0;
    while (blink_ph == b0 && n < 40000) begin @(negedge clk); n++; end
    b0 = blink_ph;
    n = 0;
    do begin @(negedge clk); n++; end while (blink_ph == b0 && n < 40000);
    check("R5 blink half period", n, 16384);

    duty9 = 1'b0;
    next_tick(n);
    next_tick(n);
    byte_strobe = 1'b1;
    @(negedge clk);
    byte_strobe = 1'b0;
    check("R6 busy set", busy, 1);
    next_tick(n);
    check("R6 busy after 1st line", busy, 1);
    next_tick(n);
    check("R6 busy after 2nd line", busy, 0);

    disp_on = 1'b0;
    #1;
    check("R7 blank on display off", blank, 1);
    c0 = com_idx;
    next_tick(n);
    check("R7 scan runs while off", com_idx, (c0 + 1) % 17);
    disp_on = 1'b1;
    #1;
    check("R7 blank clear", blank, 0);

    @(negedge clk);
    standby = 1'b1;
    c0 = com_idx;
    f0 = frame_alt;
    b0 = blink_ph;
    lines = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (line_tick) lines++;
    end
    check("R7 blank in standby", blank, 1);
    check("R8 com frozen", com_idx, c0);
    check("R8 no line ticks", lines, 0);
    check("R8 frame frozen", frame_alt, f0);
    check("R8 blink frozen", blink_ph, b0);
    standby = 1'b0;
    next_tick(n);
    check("R8 resumes", com_idx, (c0 + 1) % 17);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule